// File: doc/BRIEF.md
# CAN Error-Count Threshold Interrupt

This block watches the transmit and receive error counters of a CAN controller and tells software when either one has climbed past a warning limit. A select input picks one of two limits, 96 or 128. A registered status output, the exceeded flag, follows the comparison. A sticky pending bit records edges of that flag. The interrupt request is the pending bit qualified by three enables: a local error-interrupt enable, a module enable and a global enable.

With the low limit selected, only the flag going high makes an interrupt pending. With the high limit selected, the flag going high and the flag going low both make it pending. Software can therefore learn both when the counters cross the limit and when they recover. Software clears the pending bit by pulsing a write-one-to-clear input. The counters, the protocol engine and bus-off handling sit outside this block.

Top module: `errcnt_thresh_irq`

## Requirements
- R1: After a synchronous active-low reset, `exceeded_o` is 0 and no interrupt is pending, so `irq_o` is 0.
- R2: With `lim_sel_i` = 0 the limit is 96. `exceeded_o` becomes 1 one clock after a counter value of 97 or more is presented. A value of 96 leaves it 0.
- R3: With `lim_sel_i` = 1 the limit is 128. A value of 129 or more sets `exceeded_o` one clock later. Values up to 128, including 100 and 128, leave it 0.
- R4: The transmit counter and the receive counter are compared independently. Either one above the limit sets `exceeded_o`.
- R5: `exceeded_o` follows the comparison level. It returns to 0 one clock after both counters are at or below the limit.
- R6: With `lim_sel_i` = 0, a 0-to-1 change of `exceeded_o` makes an interrupt pending in the same clock. A 1-to-0 change does not.
- R7: With `lim_sel_i` = 1, both a 0-to-1 and a 1-to-0 change of `exceeded_o` make an interrupt pending in the same clock.
- R8: `irq_o` is 1 exactly when an interrupt is pending and `err_ie_i`, `mod_ie_i` and `glb_ie_i` are all 1. The enables act combinationally and do not clear the pending bit.
- R9: The pending bit stays set until a clock at which `pend_clr_i` is 1. If a new flag edge happens in that same clock, the pending bit stays set.
- R10: A change of `lim_sel_i` is applied on the next clock. A flag edge caused only by that change is handled under R6/R7 using the new select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_cnt_i | input | 8 | Transmit error counter value |
| rx_cnt_i | input | 8 | Receive error counter value |
| lim_sel_i | input | 1 | Limit select: 0 selects 96, 1 selects 128 |
| err_ie_i | input | 1 | Local error-count interrupt enable |
| mod_ie_i | input | 1 | Module interrupt enable |
| glb_ie_i | input | 1 | Global interrupt enable |
| pend_clr_i | input | 1 | Write-one-to-clear strobe for the pending bit |
| exceeded_o | output | 1 | Error-count-exceeded status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong comparison or a wrong limit shows on `exceeded_o` one clock after the counters reach the bad value. A missed or spurious flag edge shows on `irq_o` in the same clock as the flag change, but only while all three enables are high. For that reason the stimulus keeps the enables mostly on. A pending bit that is wrongly set, or wrongly lost, while an enable is low stays hidden until every enable is high again. At that point it shows combinationally on `irq_o`.

// File: rtl/errcnt_pkg.sv
`timescale 1ns/1ps
// Shared types for the error-count threshold interrupt block.
// Assumes: select value 0 picks the lower limit, 1 the upper limit.
package errcnt_pkg;

    // Limit selection; the encoding matches the lim_sel_i port.
    typedef enum logic {
        LIM_LOW  = 1'b0,
        LIM_HIGH = 1'b1
    } lim_mode_e;

    // Edge event seen on the exceeded flag in one clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } flag_edge_t;

endpackage

// File: rtl/errcnt_cmp.sv
`timescale 1ns/1ps
// Compares several error counters against the selected limit.
// Output is combinational: 1 when any counter is strictly above the limit.
// Assumes: both limits fit in CNT_W+1 bits; the counters are unsigned.
module errcnt_cmp
    import errcnt_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int NUM_CNT = 2,
    parameter int LIM_LO  = 96,
    parameter int LIM_HI  = 128
) (
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    input  lim_mode_e                     mode_i,
    output logic                          over_o
);
    localparam int          EXT_W  = CNT_W + 1;
    localparam logic [EXT_W-1:0] LO_EXT = EXT_W'(LIM_LO);
    localparam logic [EXT_W-1:0] HI_EXT = EXT_W'(LIM_HI);

    logic [EXT_W-1:0]   limit;
    logic [NUM_CNT-1:0] over_each;

    // Picks the active limit from the mode.
    always_comb begin
        limit = (mode_i == LIM_HIGH) ? HI_EXT : LO_EXT;
    end

    // One strict-greater comparator per counter.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cmp
        always_comb begin
            over_each[g] = {1'b0, cnt_i[g]} > limit;
        end
    end

    // Any counter above the limit raises the result.
    always_comb begin
        over_o = |over_each;
    end
endmodule

// File: rtl/errcnt_edge.sv
`timescale 1ns/1ps
// Registers the exceeded flag and keeps the sticky pending bit.
// In LIM_LOW mode only rising flag edges are recorded; in LIM_HIGH mode
// both edges are. The mode sampled is the one at the clock of the edge.
// Assumes: clr_i is a one-clock strobe; a new edge wins over a clear.
module errcnt_edge
    import errcnt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      over_i,
    input  lim_mode_e mode_i,
    input  logic      clr_i,
    output logic      flag_o,
    output logic      pend_o
);
    logic       flag_q;
    logic       pend_q;
    flag_edge_t edg;
    logic       record;

    // Finds the edge that the next clock will make on the flag.
    always_comb begin
        edg.rise = over_i & ~flag_q;
        edg.fall = ~over_i & flag_q;
    end

    // Chooses which edges count under the current mode.
    always_comb begin
        record = edg.rise | (edg.fall & (mode_i == LIM_HIGH));
    end

    // Flag register follows the comparison level.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= over_i;
    end

    // Pending bit: set on a recorded edge, cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (record) pend_q <= 1'b1;
        else if (clr_i)  pend_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/errcnt_gate.sv
`timescale 1ns/1ps
// Qualifies a request with a chain of enables; combinational.
// Assumes: every enable is active high.
module errcnt_gate #(
    parameter int NUM_EN = 3
) (
    input  logic [NUM_EN-1:0] en_i,
    input  logic              req_i,
    output logic              irq_o
);
    logic [NUM_EN:0] chain;

    // Start of the chain is the raw request.
    always_comb chain[0] = req_i;

    // Each stage passes the request on only while its enable is set.
    for (genvar g = 0; g < NUM_EN; g++) begin : g_stage
        always_comb chain[g+1] = chain[g] & en_i[g];
    end

    // End of the chain drives the request line.
    always_comb irq_o = chain[NUM_EN];
endmodule

// File: rtl/errcnt_thresh_irq.sv
`timescale 1ns/1ps
// Top of the CAN error-count threshold interrupt block.
// Compares the transmit and receive counters to 96 or 128, registers the
// exceeded flag, records flag edges in a pending bit and gates the request
// with three enables.
// Assumes: synchronous active-low reset; counters are stable unsigned values.
module errcnt_thresh_irq
    import errcnt_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int LIM_LO = 96,
    parameter int LIM_HI = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             lim_sel_i,
    input  logic             err_ie_i,
    input  logic             mod_ie_i,
    input  logic             glb_ie_i,
    input  logic             pend_clr_i,
    output logic             exceeded_o,
    output logic             irq_o
);
    localparam int NUM_CNT = 2;
    localparam int NUM_EN  = 3;

    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_EN-1:0]             en_vec;
    lim_mode_e                     mode;
    logic                          over;
    logic                          pend;

    // Gathers the counters, the enables and the mode into local buses.
    always_comb begin
        cnt_vec[0] = tx_cnt_i;
        cnt_vec[1] = rx_cnt_i;
        en_vec     = {glb_ie_i, mod_ie_i, err_ie_i};
        mode       = lim_mode_e'(lim_sel_i);
    end

    errcnt_cmp #(
        .CNT_W  (CNT_W),
        .NUM_CNT(NUM_CNT),
        .LIM_LO (LIM_LO),
        .LIM_HI (LIM_HI)
    ) u_cmp (
        .cnt_i (cnt_vec),
        .mode_i(mode),
        .over_o(over)
    );

    errcnt_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .over_i(over),
        .mode_i(mode),
        .clr_i (pend_clr_i),
        .flag_o(exceeded_o),
        .pend_o(pend)
    );

    errcnt_gate #(
        .NUM_EN(NUM_EN)
    ) u_gate (
        .en_i (en_vec),
        .req_i(pend),
        .irq_o(irq_o)
    );
endmodule

// File: rtl/errcnt_thresh_irq_chk.sv
`timescale 1ns/1ps
// Property checker for errcnt_thresh_irq, attached by bind.
// Observes the ports and the internal pending bit.
module errcnt_thresh_irq_chk #(
    parameter int CNT_W  = 8,
    parameter int LIM_LO = 96,
    parameter int LIM_HI = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] tx_cnt_i,
    input logic [CNT_W-1:0] rx_cnt_i,
    input logic             lim_sel_i,
    input logic             err_ie_i,
    input logic             mod_ie_i,
    input logic             glb_ie_i,
    input logic             pend_clr_i,
    input logic             exceeded_o,
    input logic             irq_o,
    input logic             pend
);
    logic [CNT_W:0] lim_now;
    logic           cmp_now;

    // Reference comparison built from the ports.
    always_comb begin
        lim_now = lim_sel_i ? (CNT_W+1)'(LIM_HI) : (CNT_W+1)'(LIM_LO);
        cmp_now = ({1'b0, tx_cnt_i} > lim_now) || ({1'b0, rx_cnt_i} > lim_now);
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!exceeded_o && !pend));

    // R2, R3, R4 and R5: the flag tracks the comparison one clock later.
    assert_flag_tracks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (exceeded_o == $past(cmp_now)));

    assert_rise_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exceeded_o) |-> pend);

    assert_fall_pends_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(exceeded_o) && $past(lim_sel_i)) |-> pend);

    assert_irq_needs_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (err_ie_i && mod_ie_i && glb_ie_i && pend));

    assert_pend_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !pend_clr_i) |=> pend);
endmodule

bind errcnt_thresh_irq errcnt_thresh_irq_chk #(
    .CNT_W (CNT_W),
    .LIM_LO(LIM_LO),
    .LIM_HI(LIM_HI)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_cnt_i  (tx_cnt_i),
    .rx_cnt_i  (rx_cnt_i),
    .lim_sel_i (lim_sel_i),
    .err_ie_i  (err_ie_i),
    .mod_ie_i  (mod_ie_i),
    .glb_ie_i  (glb_ie_i),
    .pend_clr_i(pend_clr_i),
    .exceeded_o(exceeded_o),
    .irq_o     (irq_o),
    .pend      (pend)
);

// File: tb/tb_errcnt_thresh_irq.sv
`timescale 1ns/1ps
module tb_errcnt_thresh_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx = 8'd0;
    logic [7:0] rx = 8'd0;
    logic       sel = 1'b0;
    logic       e1 = 1'b1, e2 = 1'b1, e3 = 1'b1;
    logic       clr = 1'b0;
    logic       exceeded_o, irq_o;

    int  nchk = 0;
    int  nbad = 0;
    logic exp_flag = 1'b0;
    logic exp_pend = 1'b0;

    always #2 clk = ~clk;

    errcnt_thresh_irq dut (
        .clk(clk), .rst_n(rst_n), .tx_cnt_i(tx), .rx_cnt_i(rx),
        .lim_sel_i(sel), .err_ie_i(e1), .mod_ie_i(e2), .glb_ie_i(e3),
        .pend_clr_i(clr), .exceeded_o(exceeded_o), .irq_o(irq_o)
    );

    function automatic logic over_ref(logic [7:0] t, logic [7:0] r, logic s);
        int lim = s ? 128 : 96;
        return (int'(t) > lim) || (int'(r) > lim);
    endfunction

    function automatic logic irq_ref(logic p, logic a, logic b, logic c);
        return p & a & b & c;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge, check after.
    task automatic cyc(logic [7:0] t, logic [7:0] r, logic s, logic c, string tag);
        logic nf;
        tx = t; rx = r; sel = s; clr = c;
        @(posedge clk);
        if (!rst_n) begin
            exp_flag = 1'b0; exp_pend = 1'b0;
        end else begin
            nf = over_ref(t, r, s);
            if ((nf && !exp_flag) || (s && !nf && exp_flag)) exp_pend = 1'b1;
            else if (c) exp_pend = 1'b0;
            exp_flag = nf;
        end
        @(negedge clk);
        chk({tag, " flag"}, exceeded_o, exp_flag);
        chk({tag, " irq"}, irq_o, irq_ref(exp_pend, e1, e2, e3));
    endtask

    initial begin
        #(200000 * 4);
        nchk++; nbad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        cyc(8'd200, 8'd200, 1'b0, 1'b0, "R1 in reset");
        cyc(8'd200, 8'd200, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        cyc(8'd0, 8'd0, 1'b0, 1'b0, "R1 after reset");
        // Low limit boundary
        cyc(8'd96, 8'd0, 1'b0, 1'b0, "R2 tx=96");
        cyc(8'd97, 8'd0, 1'b0, 1'b0, "R2 R6 tx=97");
        cyc(8'd97, 8'd0, 1'b0, 1'b1, "R9 clear");
        cyc(8'd97, 8'd0, 1'b0, 1'b0, "R9 stays clear");
        cyc(8'd96, 8'd0, 1'b0, 1'b0, "R5 R6 fall ignored low");
        cyc(8'd0, 8'd97, 1'b0, 1'b0, "R4 rx only");
        cyc(8'd0, 8'd97, 1'b0, 1'b1, "R9 clear");
        cyc(8'd0, 8'd0, 1'b0, 1'b0, "R5 both low");
        // High limit boundary
        cyc(8'd100, 8'd100, 1'b1, 1'b0, "R3 100 under high");
        cyc(8'd128, 8'd0, 1'b1, 1'b0, "R3 tx=128");
        cyc(8'd129, 8'd0, 1'b1, 1'b0, "R3 R7 tx=129");
        cyc(8'd129, 8'd0, 1'b1, 1'b1, "R9 clear");
        cyc(8'd128, 8'd128, 1'b1, 1'b0, "R7 fall pends high");
        cyc(8'd0, 8'd0, 1'b1, 1'b1, "R9 clear");
        // Select change re-evaluates
        cyc(8'd110, 8'd0, 1'b1, 1'b0, "R10 quiet high");
        cyc(8'd110, 8'd0, 1'b0, 1'b0, "R10 switch to low sets");
        cyc(8'd110, 8'd0, 1'b0, 1'b1, "R9 clear");
        cyc(8'd110, 8'd0, 1'b1, 1'b0, "R10 switch to high falls pends");
        // Enables gate the request but keep the pending bit
        e1 = 1'b0; #0;
        @(negedge clk); chk("R8 err_ie off", irq_o, 1'b0);
        e1 = 1'b1; e2 = 1'b0;
        #1 chk("R8 mod_ie off", irq_o, 1'b0);
        e2 = 1'b1; e3 = 1'b0;
        #1 chk("R8 glb_ie off", irq_o, 1'b0);
        e3 = 1'b1;
        #1 chk("R8 all back on", irq_o, 1'b1);
        cyc(8'd110, 8'd0, 1'b1, 1'b1, "R9 clear");
        // Edge and clear in the same clock: edge wins
        cyc(8'd130, 8'd0, 1'b1, 1'b1, "R9 set wins over clear");
        cyc(8'd130, 8'd0, 1'b1, 1'b1, "R9 clear");
        // Random mix near the limits
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] t, r;
            t = ($urandom % 4 == 0) ? 8'($urandom) : 8'(90 + $urandom % 45);
            r = ($urandom % 4 == 0) ? 8'($urandom) : 8'(90 + $urandom % 45);
            e1 = ($urandom % 8) != 0;
            e2 = ($urandom % 8) != 0;
            e3 = ($urandom % 8) != 0;
            cyc(t, r, ($urandom % 16) != 0 ? sel : ~sel, ($urandom % 6) == 0,
                "R8 random");
        end
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule